// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block holds a table of interrupt vectors and a bit array of pending interrupts. Each vector entry stores a 64-bit target address, a 32-bit payload and a control word. A host reads and writes the table through a 4 KiB memory-mapped window. Only full 32-bit accesses have any effect. Device logic raises interrupt requests one vector per cycle.

For each accepted request, the block does one of two things:
- If the vector is unmasked, it queues the vector for a single 32-bit message write on a request/acknowledge master port.
- If the vector is masked, it latches the vector's pending bit and sends nothing.

A later host write that leaves a pending vector unmasked releases its message. Device logic claims and releases vectors with use/unuse strobes that drive a saturating use count per vector. A vector with a zero count drops its requests, and so does any vector while the global enable input is low. Only one message is in flight at a time.

Top module: `irq_msg_table`

## Requirements
- R1: After reset, every table word reads 0, the pending word reads 0, `msg_valid` is low and every use count is zero, so every request is dropped until a vector is claimed.
- R2: Entry v occupies byte offset 16·v. Its words are the low address (+0), high address (+4), payload (+8) and control (+12). Control bit 0 is the mask, and 1 means masked. Offsets of entries at or beyond `NUM_ENTRIES` read 0 and ignore writes. Read data appears on `host_rdata` with `host_rvalid` one cycle after the read.
- R3: `host_size` is encoded 0 = byte, 1 = halfword, 2 = word. Non-word writes are discarded and non-word reads return 0.
- R4: A word read at offset 0x800 returns the pending bits, with vector v at bit v (bit v mod 8 of byte v/8). Writes there are ignored, and other offsets outside the table read 0.
- R5: An accepted request for an unmasked vector produces exactly one message with address {high word, low word} and the payload word as data.
- R6: An accepted request for a masked vector sets its pending bit and sends no message.
- R7: After a word write into entry v, if v is then unmasked and pending, its pending bit clears and its message is sent. A pending bit clears only in the cycle after such a write.
- R8: Requests are dropped when the vector index is at or above `NUM_ENTRIES`, when the vector's use count is zero, or when `enable` is low.
- R9: A use strobe increments the selected count, saturating at its maximum. An unuse strobe decrements it only when it is nonzero. Both strobes together leave it unchanged, and strobes for out-of-range vectors are ignored.
- R10: Message address and data stay stable while `msg_valid` is high without `msg_ack`, and `msg_valid` drops the cycle after the acknowledge. Requests arriving meanwhile wait in one bit per vector. Repeats for an already waiting vector merge, and waiting vectors go out lowest index first.
- R11: A request is judged against the mask as updated by a same-cycle table write. A write that unmasks a pending vector, together with a request for that vector, gives one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global request enable |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size (0 byte, 1 half, 2 word) |
| host_addr | input | 10 | Window byte offset bits 11:2 |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid |
| req_valid | input | 1 | Device interrupt request |
| req_vec | input | 5 | Requested vector |
| use_stb | input | 1 | Claim strobe |
| unuse_stb | input | 1 | Release strobe |
| use_vec | input | 5 | Vector for claim/release |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_ack | input | 1 | Message accepted |

## Verification
The assertions check every cycle that:
- an unacknowledged message holds its address and data;
- the acknowledge ends the request;
- reads answer one cycle later, with zero for sub-word sizes;
- a pending bit falls only just after a table write.

The bench scenarios show the behaviours that need history and choices:
- use-count gating and saturation;
- masking and the release of pending vectors;
- lowest-first draining and merging of queued vectors;
- the same-cycle interplay of a table write and a request.

// File: rtl/imt_pkg.sv
package imt_pkg;

    localparam int MAX_VEC     = 32;
    localparam int VIDX_W      = $clog2(MAX_VEC);
    localparam int WIN_AW      = 12;
    localparam int ENTRY_SHIFT = 4;
    localparam int MASK_BIT    = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] data;
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
    } vec_entry_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    function automatic logic [31:0] get_word(vec_entry_t e, word_sel_e s);
        case (s)
            W_ADDR_LO: return e.addr_lo;
            W_ADDR_HI: return e.addr_hi;
            W_DATA:    return e.data;
            default:   return e.ctrl;
        endcase
    endfunction

    function automatic vec_entry_t put_word(vec_entry_t e, word_sel_e s, logic [31:0] v);
        vec_entry_t r;
        r = e;
        case (s)
            W_ADDR_LO: r.addr_lo = v;
            W_ADDR_HI: r.addr_hi = v;
            W_DATA:    r.data    = v;
            default:   r.ctrl    = v;
        endcase
        return r;
    endfunction

    function automatic msg_t entry_msg(vec_entry_t e);
        msg_t m;
        m.addr = {e.addr_hi, e.addr_lo};
        m.data = e.data;
        return m;
    endfunction

endpackage

// File: rtl/imt_table.sv
module imt_table
    import imt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int ROW_W = WIN_AW - 1 - ENTRY_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [1:0]             acc_size,
    input  logic [WIN_AW-1:2]      acc_word,
    input  logic [31:0]            acc_wdata,
    input  logic [NUM_ENTRIES-1:0] pend_bits,
    output logic [31:0]            rd_data,
    output logic                   rd_valid,
    output logic                   wr_hit,
    output logic [EW-1:0]          wr_vec,
    output logic [NUM_ENTRIES-1:0] mask_cur,
    output logic [NUM_ENTRIES-1:0] mask_nxt,
    input  logic [EW-1:0]          sel_vec,
    output msg_t                   sel_msg
);

    vec_entry_t ent_q [NUM_ENTRIES];

    logic [ROW_W-1:0] row;
    logic [EW-1:0]    row_idx;
    word_sel_e        wsel;
    logic             is_word;
    logic             in_table;
    logic             in_pend;
    logic [31:0]      rd_word;

    assign row      = acc_word[WIN_AW-2:ENTRY_SHIFT];
    assign row_idx  = row[EW-1:0];
    assign wsel     = word_sel_e'(acc_word[ENTRY_SHIFT-1:2]);
    assign is_word  = (acc_size == SZ_WORD);
    assign in_table = !acc_word[WIN_AW-1] && (int'(row) < NUM_ENTRIES);
    assign in_pend  = acc_word[WIN_AW-1] && (acc_word[WIN_AW-2:2] == '0);
    assign wr_hit   = acc_valid && acc_write && is_word && in_table;
    assign wr_vec   = row_idx;
    assign sel_msg  = entry_msg(ent_q[sel_vec]);

    always_comb begin
        rd_word = '0;
        if (is_word) begin
            if (in_table)     rd_word = get_word(ent_q[row_idx], wsel);
            else if (in_pend) rd_word = 32'(pend_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rd_data <= rd_word;
            if (wr_hit) ent_q[row_idx] <= put_word(ent_q[row_idx], wsel, acc_wdata);
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_mask
        assign mask_cur[g] = ent_q[g].ctrl[MASK_BIT];
        assign mask_nxt[g] = (wr_hit && row_idx == EW'(g) && wsel == W_CTRL)
                           ? acc_wdata[MASK_BIT] : ent_q[g].ctrl[MASK_BIT];
    end

endmodule

// File: rtl/imt_usecnt.sv
module imt_usecnt
    import imt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int CNT_W       = 4,
    localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   use_stb,
    input  logic                   unuse_stb,
    input  logic [VIDX_W-1:0]      use_vec,
    output logic [NUM_ENTRIES-1:0] live
);

    logic          in_range;
    logic [EW-1:0] idx;

    assign in_range = int'(use_vec) < NUM_ENTRIES;
    assign idx      = use_vec[EW-1:0];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit     = in_range && (idx == EW'(g));
        assign live[g] = |cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit) begin
                if (use_stb && !unuse_stb && cnt_q != '1)
                    cnt_q <= cnt_q + 1'b1;
                else if (unuse_stb && !use_stb && cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/imt_sched.sv
module imt_sched
    import imt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   req_valid,
    input  logic [VIDX_W-1:0]      req_vec,
    input  logic [NUM_ENTRIES-1:0] live,
    input  logic [NUM_ENTRIES-1:0] mask_cur,
    input  logic [NUM_ENTRIES-1:0] mask_nxt,
    input  logic                   wr_hit,
    input  logic [EW-1:0]          wr_vec,
    output logic [EW-1:0]          sel_vec,
    input  msg_t                   sel_msg,
    output logic [NUM_ENTRIES-1:0] pend_q,
    output logic                   msg_valid,
    output msg_t                   msg_q,
    input  logic                   msg_ack
);

    logic [NUM_ENTRIES-1:0] queued_q, queued_d, pend_d;
    logic [EW-1:0]          req_idx;
    logic                   req_ok, wchk, launch_go, send;

    assign req_idx   = req_vec[EW-1:0];
    assign req_ok    = req_valid && enable && (int'(req_vec) < NUM_ENTRIES) && live[req_idx];
    assign wchk      = wr_hit && !mask_nxt[wr_vec] && pend_q[wr_vec];
    assign launch_go = !msg_valid && !wr_hit && (|queued_q);
    assign send      = launch_go && !mask_cur[sel_vec];

    always_comb begin
        sel_vec = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--)
            if (queued_q[i]) sel_vec = EW'(i);
    end

    always_comb begin
        queued_d = queued_q;
        pend_d   = pend_q;
        if (launch_go) begin
            queued_d[sel_vec] = 1'b0;
            if (mask_cur[sel_vec]) pend_d[sel_vec] = 1'b1;
        end
        if (wchk) begin
            pend_d[wr_vec]   = 1'b0;
            queued_d[wr_vec] = 1'b1;
        end
        if (req_ok) begin
            if (mask_nxt[req_idx]) pend_d[req_idx]   = 1'b1;
            else                   queued_d[req_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            queued_q  <= '0;
            pend_q    <= '0;
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else begin
            queued_q <= queued_d;
            pend_q   <= pend_d;
            if (send) begin
                msg_valid <= 1'b1;
                msg_q     <= sel_msg;
            end else if (msg_ack) begin
                msg_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_msg_table.sv
module irq_msg_table
    import imt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int CNT_W       = 4,
    localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [1:0]        host_size,
    input  logic [WIN_AW-1:2] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    input  logic              req_valid,
    input  logic [VIDX_W-1:0] req_vec,
    input  logic              use_stb,
    input  logic              unuse_stb,
    input  logic [VIDX_W-1:0] use_vec,
    output logic              msg_valid,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    input  logic              msg_ack
);

    logic [NUM_ENTRIES-1:0] pend_bits, mask_cur, mask_nxt, live;
    logic                   wr_hit;
    logic [EW-1:0]          wr_vec, sel_vec;
    msg_t                   sel_msg, msg_q;

    imt_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk(clk), .rst(rst),
        .acc_valid(host_valid), .acc_write(host_write), .acc_size(host_size),
        .acc_word(host_addr), .acc_wdata(host_wdata),
        .pend_bits(pend_bits),
        .rd_data(host_rdata), .rd_valid(host_rvalid),
        .wr_hit(wr_hit), .wr_vec(wr_vec),
        .mask_cur(mask_cur), .mask_nxt(mask_nxt),
        .sel_vec(sel_vec), .sel_msg(sel_msg)
    );

    imt_usecnt #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_usecnt (
        .clk(clk), .rst(rst),
        .use_stb(use_stb), .unuse_stb(unuse_stb), .use_vec(use_vec),
        .live(live)
    );

    imt_sched #(.NUM_ENTRIES(NUM_ENTRIES)) u_sched (
        .clk(clk), .rst(rst), .enable(enable),
        .req_valid(req_valid), .req_vec(req_vec),
        .live(live), .mask_cur(mask_cur), .mask_nxt(mask_nxt),
        .wr_hit(wr_hit), .wr_vec(wr_vec),
        .sel_vec(sel_vec), .sel_msg(sel_msg),
        .pend_q(pend_bits),
        .msg_valid(msg_valid), .msg_q(msg_q), .msg_ack(msg_ack)
    );

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

endmodule

// File: rtl/irq_msg_table_chk.sv
module irq_msg_table_chk #(
    parameter int NUM_ENTRIES = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   host_valid,
    input logic                   host_write,
    input logic [1:0]             host_size,
    input logic [31:0]            host_rdata,
    input logic                   host_rvalid,
    input logic                   msg_valid,
    input logic                   msg_ack,
    input logic [63:0]            msg_addr,
    input logic [31:0]            msg_data,
    input logic [NUM_ENTRIES-1:0] pend_bits,
    input logic                   wr_hit
);

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ack |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R10

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ack |=> !msg_valid); // R10

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        host_valid && !host_write |=> host_rvalid); // R2

    AST_SUBWORD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_valid && !host_write && host_size != 2'd2 |=> host_rdata == 32'd0); // R3

    AST_PEND_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend_bits) & ~pend_bits)) |-> $past(wr_hit)); // R7

endmodule

bind irq_msg_table irq_msg_table_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .msg_valid(msg_valid), .msg_ack(msg_ack),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .pend_bits(pend_bits), .wr_hit(wr_hit)
);

// File: tb/irq_msg_table_bench.sv
`timescale 1ns/1ps
module irq_msg_table_bench;

    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [1:0]  host_size = 2'd2;
    logic [11:2] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        use_stb = 1'b0, unuse_stb = 1'b0;
    logic [4:0]  use_vec = '0;
    logic        msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        msg_ack = 1'b0;

    int n_chk = 0, n_fail = 0, n_msg = 0;
    bit auto_ack = 1'b1, done = 1'b0;
    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [31:0] mdl [NE][4];

    always #10 clk = ~clk;

    irq_msg_table #(.NUM_ENTRIES(NE), .CNT_W(4)) u_irq_msg_table (
        .clk(clk), .rst(rst), .enable(enable),
        .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .req_valid(req_valid), .req_vec(req_vec),
        .use_stb(use_stb), .unuse_stb(unuse_stb), .use_vec(use_vec),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_ack(msg_ack)
    );

    always @(negedge clk) msg_ack = auto_ack && msg_valid;

    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ack) begin
            log_addr[n_msg % 64] = msg_addr;
            log_data[n_msg % 64] = msg_data;
            n_msg = n_msg + 1;
        end
    end

    function automatic logic [63:0] exp_addr(int v);
        return {32'h0000_00A0 + 32'(v), 32'h1000_0000 + 32'(v * 16)};
    endfunction

    function automatic logic [31:0] exp_data(int v);
        return 32'hD00D_0000 + 32'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a[11:2]; host_wdata = d; host_size = sz;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic hrd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d, output logic rv);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a[11:2]; host_size = sz;
        @(negedge clk);
        host_valid = 1'b0;
        d = host_rdata; rv = host_rvalid;
    endtask

    task automatic preq(input int v);
        req_valid = 1'b1; req_vec = 5'(v);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic puse(input int v, input bit u, input bit un);
        use_stb = u; unuse_stb = un; use_vec = 5'(v);
        @(negedge clk);
        use_stb = 1'b0; unuse_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic rv;
        int base;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NE; i++) for (int j = 0; j < 4; j++) mdl[i][j] = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(msg_valid == 1'b0, "R1 msg_valid idle", 64'(msg_valid), 64'd0);
        hrd(12'h00C, 2'd2, rd, rv);
        chk(rd == 32'd0, "R1 table word zero", 64'(rd), 64'd0);
        chk(rv == 1'b1, "R2 read valid latency", 64'(rv), 64'd1);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'd0, "R1 pending zero", 64'(rd), 64'd0);

        // R2/R3 random table traffic against a bench model
        for (int k = 0; k < 120; k++) begin
            int v;
            int w;
            logic [1:0] sz;
            logic [31:0] d;
            logic [11:0] a;
            v = int'($urandom % 10);
            w = int'($urandom % 4);
            sz = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'd2;
            d = $urandom;
            a = 12'(v * 16 + w * 4);
            if ($urandom % 2 == 1) begin
                hwr(a, d, sz);
                if (sz == 2'd2 && v < NE) mdl[v][w] = d;
            end else begin
                logic [31:0] e;
                hrd(a, sz, rd, rv);
                e = (sz == 2'd2 && v < NE) ? mdl[v][w] : 32'd0;
                chk(rd == e, (sz != 2'd2) ? "R3 subword read" : "R2 table read", 64'(rd), 64'(e));
            end
        end

        // program every entry
        for (int v = 0; v < NE; v++) begin
            logic [63:0] ea;
            ea = exp_addr(v);
            hwr(12'(v * 16 + 0), ea[31:0], 2'd2);
            hwr(12'(v * 16 + 4), ea[63:32], 2'd2);
            hwr(12'(v * 16 + 8), exp_data(v), 2'd2);
            hwr(12'(v * 16 + 12), 32'd0, 2'd2);
        end
        hrd(12'h098, 2'd2, rd, rv);
        chk(rd == 32'd0, "R2 out-of-range entry", 64'(rd), 64'd0);

        // R8 zero use count, then R5 send
        base = n_msg;
        preq(2); cyc(6);
        chk(n_msg == base, "R8 unused vector dropped", 64'(n_msg - base), 64'd0);
        puse(2, 1, 0);
        preq(2); cyc(6);
        chk(n_msg == base + 1, "R5 one message", 64'(n_msg - base), 64'd1);
        chk(log_addr[base % 64] == exp_addr(2), "R5 address", log_addr[base % 64], exp_addr(2));
        chk(log_data[base % 64] == exp_data(2), "R5 data", 64'(log_data[base % 64]), 64'(exp_data(2)));

        // R6 masked request, R3/R4 ignored writes, R7 release
        hwr(12'h03C, 32'd1, 2'd2);
        puse(3, 1, 0);
        base = n_msg;
        preq(3); cyc(6);
        chk(n_msg == base, "R6 masked no message", 64'(n_msg - base), 64'd0);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'h0000_0008, "R6 pending bit 3", 64'(rd), 64'h8);
        hwr(12'h038, exp_data(3), 2'd2); cyc(4);
        chk(n_msg == base, "R7 masked write keeps pending", 64'(n_msg - base), 64'd0);
        hwr(12'h03C, 32'd0, 2'd0); cyc(4);
        hrd(12'h03C, 2'd2, rd, rv);
        chk(rd == 32'd1 && n_msg == base, "R3 byte write discarded", 64'(rd), 64'd1);
        hwr(12'h800, 32'd0, 2'd2);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'h8, "R4 pending write ignored", 64'(rd), 64'h8);
        hrd(12'h804, 2'd2, rd, rv);
        chk(rd == 32'd0, "R4 other offset zero", 64'(rd), 64'd0);
        hwr(12'h03C, 32'd0, 2'd2); cyc(6);
        chk(n_msg == base + 1, "R7 release sends", 64'(n_msg - base), 64'd1);
        chk(log_addr[base % 64] == exp_addr(3), "R7 address", log_addr[base % 64], exp_addr(3));
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'd0, "R7 pending cleared", 64'(rd), 64'd0);

        // R8 out of range and disabled
        base = n_msg;
        puse(9, 1, 0);
        preq(9); preq(31); cyc(6);
        chk(n_msg == base, "R8 out-of-range dropped", 64'(n_msg - base), 64'd0);
        enable = 1'b0;
        preq(2); cyc(6);
        enable = 1'b1;
        chk(n_msg == base, "R8 disabled dropped", 64'(n_msg - base), 64'd0);

        // R9 use counting
        puse(2, 1, 0);
        puse(2, 0, 1); puse(2, 0, 1);
        base = n_msg;
        preq(2); cyc(6);
        chk(n_msg == base, "R9 count back to zero", 64'(n_msg - base), 64'd0);
        puse(2, 0, 1);
        puse(2, 1, 0);
        preq(2); cyc(6);
        chk(n_msg == base + 1, "R9 no wrap below zero", 64'(n_msg - base), 64'd1);
        puse(2, 1, 1);
        puse(2, 0, 1);
        base = n_msg;
        preq(2); cyc(6);
        chk(n_msg == base, "R9 simultaneous strobes no change", 64'(n_msg - base), 64'd0);
        for (int i = 0; i < 17; i++) puse(6, 1, 0);
        for (int i = 0; i < 14; i++) puse(6, 0, 1);
        preq(6); cyc(6);
        chk(n_msg == base + 1, "R9 saturation keeps one", 64'(n_msg - base), 64'd1);
        puse(6, 0, 1);
        preq(6); cyc(6);
        chk(n_msg == base + 1, "R9 saturated count drained", 64'(n_msg - base), 64'd1);

        // R10 backpressure, ordering and merging
        puse(4, 1, 0); puse(5, 1, 0);
        auto_ack = 1'b0;
        base = n_msg;
        preq(5); preq(4); preq(5); preq(4);
        cyc(8);
        chk(msg_valid == 1'b1 && msg_addr == exp_addr(5), "R10 held without ack", msg_addr, exp_addr(5));
        auto_ack = 1'b1;
        cyc(20);
        chk(n_msg == base + 3, "R10 merged count", 64'(n_msg - base), 64'd3);
        chk(log_addr[base % 64] == exp_addr(5), "R10 first", log_addr[base % 64], exp_addr(5));
        chk(log_addr[(base + 1) % 64] == exp_addr(4), "R10 lowest next", log_addr[(base + 1) % 64], exp_addr(4));
        chk(log_addr[(base + 2) % 64] == exp_addr(5), "R10 last", log_addr[(base + 2) % 64], exp_addr(5));

        // R11 same-cycle write and request
        hwr(12'h03C, 32'd1, 2'd2);
        preq(3); cyc(3);
        base = n_msg;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 10'(12'h03C >> 2); host_wdata = 32'd0; host_size = 2'd2;
        req_valid = 1'b1; req_vec = 5'd3;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0; req_valid = 1'b0;
        cyc(8);
        chk(n_msg == base + 1, "R11 coalesced single message", 64'(n_msg - base), 64'd1);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'd0, "R11 pending cleared", 64'(rd), 64'd0);
        base = n_msg;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 10'(12'h03C >> 2); host_wdata = 32'd1; host_size = 2'd2;
        req_valid = 1'b1; req_vec = 5'd3;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0; req_valid = 1'b0;
        cyc(6);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'h8 && n_msg == base, "R11 request sees new mask", 64'(rd), 64'h8);

        // R1 reset again
        do_reset();
        hrd(12'h020, 2'd2, rd, rv);
        chk(rd == 32'd0, "R1 table cleared", 64'(rd), 64'd0);
        hrd(12'h800, 2'd2, rd, rv);
        chk(rd == 32'd0, "R1 pending cleared", 64'(rd), 64'd0);
        base = n_msg;
        preq(2); cyc(6);
        chk(n_msg == base, "R1 counts cleared", 64'(n_msg - base), 64'd0);

        finish_run();
    end

endmodule